// File: doc/BRIEF.md
# Signature Operation Sequencer

This block is the control plane of a public-key signature core. It accepts one of three operations from a host: derive a public key, sign, or verify. For each one it walks a fixed chain of steps. Each step hands one request to one child engine: hash, scalar reduce, scalar multiply, point codec (compress or decode), canonical-encoding check, small-order check, point add, conversion to the cached addition form, or scalar multiply-add. The arithmetic lives in those engines. The sequencer only orders their work, registers each completion, and turns the outcome into a result code that it holds.

A sign request runs in one of two ways. With no key cached, it first runs the whole key-derivation chain and then the signing chain. Once a successful derivation has set the key-cached flag, a sign request starts directly at the nonce hash. Verification runs cheap rejection gates first: canonical encoding, decoding both points, and a small-order test on each point. Any failure at any step ends the operation at once. The expensive double scalar multiplication is never reached after a failed gate.

Top module: `sigseq_top`

## Requirements
- R1: A derive command (`cmd_op`=0) makes exactly four requests in this order: hash, reduce, scalar multiply, codec compress. It then presents result code 0 (success).
- R2: A sign command (`cmd_op`=1) with `key_cached` low makes the four derive requests and then seven more: hash, reduce, scalar multiply, codec compress, hash, reduce, multiply-add. It ends with code 0.
- R3: A sign command with `key_cached` high makes only the seven signing requests listed in R2.
- R4: `key_cached` is low after reset. It rises only when the codec-compress step of the key chain completes without error. Once set, it stays high until reset.
- R5: A verify command (`cmd_op`=2) requests, in order: canonical check, decode, small-order, compress, decode, small-order, compress, hash, reduce, scalar multiply, scalar multiply, cached-form conversion, point add, compress. It ends with code 0 when no step reports an error.
- R6: An error during verification ends the operation right after the failing step, with no further request. The reject codes are: 1 for the canonical check, 2 for either decode, 3 for either small-order step or the compress step that follows it, and 4 for the final compress.
- R7: An error from any other verification step, or from any derive or sign step, ends the operation with code 5 (engine fault).
- R8: At most one bit of `eng_req` is high at a time. A request stays high until the engine raises its `eng_ready` bit. The request drops in the cycle after it is accepted.
- R9: `result_valid` and `result_code` hold steady until `result_ack`. The cycle after the acknowledge, the block is idle again. Commands presented while an operation is running are ignored.
- R10: After reset, `cmd_ready` is high and `eng_req` and `result_valid` are low.
- R11: An engine's done pulse is first registered. The following step's request appears no earlier than two cycles after the done pulse.
- R12: A command with the reserved opcode 3 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 derive, 1 sign, 2 verify, 3 reserved |
| cmd_ready | output | 1 | Idle; a command is taken in this cycle |
| eng_req | output | 9 | Request per engine: 0 hash, 1 reduce, 2 scalar mul, 3 codec, 4 canonical, 5 small-order, 6 point add, 7 cached-form, 8 multiply-add |
| codec_decode | output | 1 | With a codec request: 1 decode, 0 compress |
| eng_ready | input | 9 | Engine accepts its request |
| eng_done | input | 9 | Engine completion pulse |
| eng_err | input | 9 | Error flag, valid with the done pulse |
| key_cached | output | 1 | Derived key is retained |
| result_valid | output | 1 | Result held |
| result_code | output | 3 | Outcome code, valid with `result_valid` |
| result_ack | input | 1 | Host releases the result |

## Verification
The assertions assume well-behaved engines. An engine pulses done only while its own request has been accepted and is still awaited. It never raises done in the same cycle it accepts. Its error flag is read only alongside done. The bench's single engine stub keeps to this. It serves one request at a time: it stalls the ready signal for a chosen number of cycles, and it pulses done a chosen latency after acceptance, with a latency of one cycle or more. Commands and acknowledges are driven only on falling edges. During busy-time command noise, the command line is dropped before the result is acknowledged.

// File: rtl/sigseq_pkg.sv
package sigseq_pkg;
    localparam int NUM_ENG = 9;
    localparam int ENG_W   = $clog2(NUM_ENG);
    localparam int OP_W    = 2;
    localparam int CODE_W  = 3;
    localparam int STEP_W  = 5;

    typedef enum logic [OP_W-1:0] {OP_DERIVE, OP_SIGN, OP_VERIFY, OP_RSVD} op_e;

    typedef enum logic [ENG_W-1:0] {
        E_HASH, E_REDUCE, E_SMUL, E_CODEC, E_CANON, E_SMALL, E_PADD, E_NIELS, E_MULADD
    } eng_e;

    // Chain order matters: successor of a plain step is the next encoding.
    typedef enum logic [STEP_W-1:0] {
        ST_IDLE,
        ST_K_HASH, ST_K_REDUCE, ST_K_MUL, ST_K_CMP,
        ST_S_NHASH, ST_S_NREDUCE, ST_S_RMUL, ST_S_RCMP, ST_S_CHASH, ST_S_CREDUCE, ST_S_MULADD,
        ST_V_CANON, ST_V_DEC_A, ST_V_SMALL_A, ST_V_IDENT_A, ST_V_DEC_R, ST_V_SMALL_R,
        ST_V_IDENT_R, ST_V_HASH, ST_V_KREDUCE, ST_V_SMUL, ST_V_KMUL, ST_V_NIELS, ST_V_ADD,
        ST_V_CMP,
        ST_RESULT
    } step_e;

    typedef enum logic [1:0] {PH_ISSUE, PH_WAIT, PH_DONE} phase_e;

    localparam logic [CODE_W-1:0] RC_OK       = 3'd0;
    localparam logic [CODE_W-1:0] RC_ENCODING = 3'd1;
    localparam logic [CODE_W-1:0] RC_DECODE   = 3'd2;
    localparam logic [CODE_W-1:0] RC_SMALL    = 3'd3;
    localparam logic [CODE_W-1:0] RC_MISMATCH = 3'd4;
    localparam logic [CODE_W-1:0] RC_FAULT    = 3'd5;

    // Status seen by the transition kernel: no data, only control.
    typedef struct packed {
        step_e  step;
        phase_e phase;
        logic   err;
        op_e    op;
        logic   cached;
    } seq_status_t;

    typedef struct packed {
        step_e             step;
        phase_e            phase;
        logic              err;
        op_e               op;
        logic              cached;
        logic [CODE_W-1:0] code;
    } seq_regs_t;

    function automatic eng_e engine_of(step_e s);
        case (s)
            ST_K_HASH, ST_S_NHASH, ST_S_CHASH, ST_V_HASH:        return E_HASH;
            ST_K_REDUCE, ST_S_NREDUCE, ST_S_CREDUCE, ST_V_KREDUCE: return E_REDUCE;
            ST_K_MUL, ST_S_RMUL, ST_V_SMUL, ST_V_KMUL:          return E_SMUL;
            ST_V_CANON:                                         return E_CANON;
            ST_V_SMALL_A, ST_V_SMALL_R:                         return E_SMALL;
            ST_V_ADD:                                           return E_PADD;
            ST_V_NIELS:                                         return E_NIELS;
            ST_S_MULADD:                                        return E_MULADD;
            default:                                            return E_CODEC;
        endcase
    endfunction

    function automatic logic uses_engine(step_e s);
        return (s != ST_IDLE) && (s != ST_RESULT);
    endfunction

    function automatic logic is_decode(step_e s);
        return (s == ST_V_DEC_A) || (s == ST_V_DEC_R);
    endfunction

    function automatic logic [CODE_W-1:0] fail_code(step_e s);
        case (s)
            ST_V_CANON:                                          return RC_ENCODING;
            ST_V_DEC_A, ST_V_DEC_R:                              return RC_DECODE;
            ST_V_SMALL_A, ST_V_IDENT_A, ST_V_SMALL_R, ST_V_IDENT_R: return RC_SMALL;
            ST_V_CMP:                                            return RC_MISMATCH;
            default:                                             return RC_FAULT;
        endcase
    endfunction
endpackage

// File: rtl/sigseq_transition.sv
module sigseq_transition
    import sigseq_pkg::*;
(
    input  seq_status_t stat,
    input  logic        cmd_valid,
    input  op_e         cmd_op,
    input  logic        ack,
    output step_e       step_next,
    output logic        accept
);
    always_comb begin
        step_next = stat.step;
        accept    = 1'b0;
        case (stat.step)
            ST_IDLE: begin
                if (cmd_valid && cmd_op != OP_RSVD) begin
                    accept = 1'b1;
                    case (cmd_op)
                        OP_VERIFY: step_next = ST_V_CANON;
                        OP_SIGN:   step_next = stat.cached ? ST_S_NHASH : ST_K_HASH;
                        default:   step_next = ST_K_HASH;
                    endcase
                end
            end
            ST_RESULT: begin
                if (ack) step_next = ST_IDLE;
            end
            default: begin
                if (stat.phase == PH_DONE) begin
                    if (stat.err) begin
                        step_next = ST_RESULT;
                    end else begin
                        case (stat.step)
                            ST_K_CMP:              step_next = (stat.op == OP_SIGN) ? ST_S_NHASH : ST_RESULT;
                            ST_S_MULADD, ST_V_CMP: step_next = ST_RESULT;
                            default:               step_next = step_e'(stat.step + 5'd1);
                        endcase
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/sigseq_commands.sv
module sigseq_commands
    import sigseq_pkg::*;
(
    input  step_e              step,
    input  phase_e             phase,
    output logic [NUM_ENG-1:0] req,
    output logic               decode_mode
);
    eng_e sel;
    logic active;

    assign sel         = engine_of(step);
    assign active      = uses_engine(step) && (phase == PH_ISSUE);
    assign decode_mode = is_decode(step);

    for (genvar i = 0; i < NUM_ENG; i++) begin : g_req
        assign req[i] = active && (sel == eng_e'(ENG_W'(i)));
    end
endmodule

// File: rtl/sigseq_top.sv
module sigseq_top
    import sigseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [OP_W-1:0]    cmd_op,
    output logic               cmd_ready,
    output logic [NUM_ENG-1:0] eng_req,
    output logic               codec_decode,
    input  logic [NUM_ENG-1:0] eng_ready,
    input  logic [NUM_ENG-1:0] eng_done,
    input  logic [NUM_ENG-1:0] eng_err,
    output logic               key_cached,
    output logic               result_valid,
    output logic [CODE_W-1:0]  result_code,
    input  logic               result_ack
);
    seq_regs_t   r_d, r_q;
    seq_status_t stat;
    step_e       step_next;
    logic        accept;
    eng_e        sel;

    assign stat = '{step: r_q.step, phase: r_q.phase, err: r_q.err, op: r_q.op, cached: r_q.cached};
    assign sel  = engine_of(r_q.step);

    sigseq_transition u_trans (
        .stat      (stat),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_e'(cmd_op)),
        .ack       (result_ack),
        .step_next (step_next),
        .accept    (accept)
    );

    sigseq_commands u_cmds (
        .step        (r_q.step),
        .phase       (r_q.phase),
        .req         (eng_req),
        .decode_mode (codec_decode)
    );

    // Register-update kernel: completions and result data captured here.
    always_comb begin
        r_d      = r_q;
        r_d.step = step_next;
        if (accept) begin
            r_d.op    = op_e'(cmd_op);
            r_d.phase = PH_ISSUE;
            r_d.err   = 1'b0;
        end else if (uses_engine(r_q.step)) begin
            case (r_q.phase)
                PH_ISSUE: if (eng_ready[sel]) r_d.phase = PH_WAIT;
                PH_WAIT: begin
                    if (eng_done[sel]) begin
                        r_d.phase = PH_DONE;
                        r_d.err   = eng_err[sel];
                    end
                end
                default: begin
                    r_d.phase = PH_ISSUE;
                    if (!r_q.err && r_q.step == ST_K_CMP) r_d.cached = 1'b1;
                    if (step_next == ST_RESULT) r_d.code = r_q.err ? fail_code(r_q.step) : RC_OK;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{step: ST_IDLE, phase: PH_ISSUE, err: 1'b0, op: OP_DERIVE, cached: 1'b0, code: RC_OK};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready    = (r_q.step == ST_IDLE);
    assign result_valid = (r_q.step == ST_RESULT);
    assign result_code  = r_q.code;
    assign key_cached   = r_q.cached;

    a_r8_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_req));

    for (genvar i = 0; i < NUM_ENG; i++) begin : g_chk
        a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
            eng_req[i] && !eng_ready[i] |=> eng_req[i]);
        a_r8_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
            eng_req[i] && eng_ready[i] |=> !eng_req[i]);
        // Input assumption: done only from the engine that is awaited.
        a_r8_done_when_awaited: assert property (@(posedge clk) disable iff (!rst_n)
            eng_done[i] |-> (r_q.phase == PH_WAIT) && (sel == eng_e'(ENG_W'(i))));
    end

    a_r11_done_registered: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_done) |=> (eng_req == '0));

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && !result_ack |=> result_valid && $stable(result_code));

    a_r9_release_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && result_ack |=> cmd_ready);

    a_r4_cache_set: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.step == ST_K_CMP) && (r_q.phase == PH_DONE) && !r_q.err |=> key_cached);

    a_r4_cache_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        key_cached |=> key_cached);

    a_r6_error_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_DONE) && r_q.err |=> result_valid && (result_code != RC_OK));
endmodule

// File: tb/test_sigseq_top.sv
module test_sigseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 9;

    // Expected engine codes: engine index * 2 + decode flag.
    localparam int KEY_SEQ [4]  = '{0, 2, 4, 6};
    localparam int SIGN_SEQ [7] = '{0, 2, 4, 6, 0, 2, 16};
    localparam int VER_SEQ [14] = '{8, 7, 10, 6, 7, 10, 6, 0, 2, 4, 4, 14, 12, 6};

    typedef struct packed {
        logic [1:0] op;
        int path;    // 0 derive, 1 cold sign, 2 warm sign, 3 verify
        int err_at;  // request index that reports an error, -1 none
        int code;
        int cnt;
        int stall;
        int lat;
        bit noise;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd1, 1, -1,  0, 11, 0, 1, 1'b0},
        '{2'd1, 2, -1,  0,  7, 2, 3, 1'b1},
        '{2'd0, 0, -1,  0,  4, 1, 2, 1'b0},
        '{2'd2, 3, -1,  0, 14, 0, 1, 1'b1},
        '{2'd2, 3,  0,  1,  1, 1, 1, 1'b0},
        '{2'd2, 3,  1,  2,  2, 0, 2, 1'b0},
        '{2'd2, 3,  5,  3,  6, 1, 1, 1'b0},
        '{2'd2, 3,  3,  3,  4, 0, 1, 1'b0},
        '{2'd2, 3, 13,  4, 14, 0, 1, 1'b0},
        '{2'd2, 3,  8,  5,  9, 2, 1, 1'b0},
        '{2'd1, 2,  6,  5,  7, 0, 2, 1'b0},
        '{2'd0, 0,  3,  5,  4, 0, 1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          cmd_ready;
    logic [NE-1:0] eng_req;
    logic          codec_decode;
    logic [NE-1:0] eng_ready = '0;
    logic [NE-1:0] eng_done = '0;
    logic [NE-1:0] eng_err = '0;
    logic          key_cached;
    logic          result_valid;
    logic [2:0]    result_code;
    logic          result_ack = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit cache_exp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sigseq_top i_sigseq_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .eng_req(eng_req), .codec_decode(codec_decode),
        .eng_ready(eng_ready), .eng_done(eng_done), .eng_err(eng_err),
        .key_cached(key_cached), .result_valid(result_valid),
        .result_code(result_code), .result_ack(result_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_at(int path, int k);
        case (path)
            0:       return KEY_SEQ[k];
            1:       return (k < 4) ? KEY_SEQ[k] : SIGN_SEQ[k-4];
            2:       return SIGN_SEQ[k];
            default: return VER_SEQ[k];
        endcase
    endfunction

    function automatic string path_req(int path);
        case (path)
            0:       return "R1 derive order";
            1:       return "R2 cold sign order";
            2:       return "R3 warm sign order";
            default: return "R5 verify order";
        endcase
    endfunction

    task automatic run_op(input vec_t v);
        int nreq = 0;
        int cyc = 0;
        int idx;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = v.op;
        @(negedge clk);
        if (v.noise) cmd_op = (v.op == 2'd0) ? 2'd2 : 2'd0;   // R9: ignored while busy
        else cmd_valid = 1'b0;
        while (!result_valid && cyc < 3000) begin
            if (|eng_req) begin
                idx = 0;
                for (int j = 0; j < NE; j++) if (eng_req[j]) idx = j;
                check($countones(eng_req) == 1, "R8 one request", $countones(eng_req), 1);
                if (nreq < v.cnt)
                    check(idx*2 + int'(codec_decode) == exp_at(v.path, nreq), path_req(v.path),
                          idx*2 + int'(codec_decode), exp_at(v.path, nreq));
                else
                    check(1'b0, "R6 no request after end", nreq, v.cnt);
                for (int s = 0; s < v.stall; s++) begin
                    @(negedge clk);
                    check(eng_req[idx], "R8 held under stall", eng_req[idx], 1);
                end
                eng_ready[idx] = 1'b1;
                @(negedge clk);
                eng_ready[idx] = 1'b0;
                check(eng_req == '0, "R8 drop after accept", int'(eng_req), 0);
                for (int l = 1; l < v.lat; l++) @(negedge clk);
                eng_done[idx] = 1'b1;
                eng_err[idx] = (nreq == v.err_at);
                @(negedge clk);
                eng_done = '0;
                eng_err = '0;
                check(eng_req == '0, "R11 registered completion", int'(eng_req), 0);
                nreq++;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        cmd_valid = 1'b0;
        check(result_valid, "R9 result reached", result_valid, 1);
        check(nreq == v.cnt, (v.err_at >= 0) ? "R6/R7 request count" : path_req(v.path), nreq, v.cnt);
        check(int'(result_code) == v.code, (v.code == 5) ? "R7 fault code" : "R6 result code",
              result_code, v.code);
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            check(result_valid && int'(result_code) == v.code, "R9 held until ack", result_code, v.code);
        end
        if ((v.path <= 1) && (v.err_at < 0 || v.err_at > 3)) cache_exp = 1'b1;
        check(key_cached == cache_exp, "R4 cache flag", key_cached, cache_exp);
        result_ack = 1'b1;
        @(negedge clk);
        result_ack = 1'b0;
        check(cmd_ready && !result_valid, "R9 back to idle", cmd_ready, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && eng_req == '0 && !result_valid, "R10 reset state", int'(eng_req), 0);
        check(!key_cached, "R4 clear after reset", key_cached, 0);

        for (int i = 0; i < 12; i++) run_op(VECS[i]);

        // Reset drops the cache; a failed key compress must not set it.
        @(negedge clk);
        rst_n = 1'b0;
        cache_exp = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !result_valid && !key_cached, "R10 reset again", key_cached, 0);
        run_op('{2'd0, 0, 3, 5, 4, 0, 1, 1'b0});
        check(!key_cached, "R4 not set on error", key_cached, 0);
        run_op('{2'd1, 1, -1, 0, 11, 1, 1, 1'b0});   // R2: cold path still taken

        // Reserved opcode
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            check(cmd_ready && eng_req == '0, "R12 reserved op ignored", int'(eng_req), 0);
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule